// File: doc/BRIEF.md
# Nibble Accumulator and Data-Pointer Unit

This block is the 4-bit datapath of a small controller. It holds an accumulator, a data pointer made of a high nibble and a low nibble, four spare accumulator registers, two spare copies of each pointer nibble, and a zero flag. A sequencer presents one decoded 8-bit opcode at a time with a valid strobe. The unit runs the load, store, exchange, pointer-step and transfer operations against a nibble-wide RAM. The RAM address is the pointer, with the high nibble as the upper four address bits.

Most operations complete in the cycle in which the opcode is presented. An exchange of the accumulator with memory takes two cycles. The first cycle reads the RAM nibble. The second writes the old accumulator back, loads the fetched nibble and then post-modifies the pointer. A `done` pulse marks the last cycle of every operation. While an exchange is in its second cycle, the valid strobe is not looked at.

Top module: `nibble_acc_unit`

## Requirements
- R1: During and directly after reset, the accumulator, both pointer nibbles, the zero flag, all spare registers, `done` and `memWe` are 0.
- R2: Opcode 1100_iiii loads iiii into the accumulator. Opcode 1000_iiii clears the pointer high nibble and loads iiii into the low nibble. Opcode 0100_iiii loads iiii into the high nibble. None of the three changes the zero flag.
- R3: Opcode 0000_0010 raises `memWe` in the same cycle, with `memWdata` equal to the accumulator and `memAddr` equal to {high, low}.
- R4: Opcode 0010_0001 loads the RAM nibble at {high, low} into the accumulator and sets the zero flag exactly when that nibble is 0.
- R5: Opcode 1010_0mmm swaps the accumulator with the RAM nibble at the current pointer. The high nibble then becomes high OR 0mmm, and the zero flag is set exactly when the new high nibble is 0 (mmm = 000 is the plain exchange).
- R6: Opcode 1111_1110 swaps the accumulator with RAM and then adds 1 to the low nibble. Opcode 1111_1111 swaps and then subtracts 1. The step wraps modulo 16, never alters the high nibble, and the zero flag follows the new low nibble.
- R7: Opcodes 1110_1110 (add 1) and 1110_1111 (subtract 1) step the low nibble modulo 16 without touching the high nibble, and set the zero flag from the result.
- R8: Opcode 1111_0111 copies the accumulator into the low nibble and leaves the zero flag alone. Opcode 1110_1001 copies the low nibble into the accumulator and sets the zero flag from it.
- R9: Opcode 0010_0011 swaps the accumulator with the high nibble. Opcode 1110_tt00 swaps the accumulator with spare register tt. Neither changes the zero flag.
- R10: Opcode 1111_1a00 swaps the high nibble with high spare a. Opcode 1111_0a00 swaps the low nibble with low spare a. Neither changes the zero flag.
- R11: `done` is high in the cycle the opcode is presented for every operation except the three memory exchanges. For a memory exchange, `done` and `memWe` are low in the first cycle and both high in the second. A valid opcode presented during that second cycle has no effect.
- R12: Every other opcode is a one-cycle no-operation. It raises `done`, writes no RAM and changes no register or flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| opValid | input | 1 | Opcode present this cycle |
| opcode | input | 8 | Operation to run |
| memRdata | input | 4 | RAM read data for `memAddr`, combinational |
| memAddr | output | 8 | RAM address {high, low} |
| memWdata | output | 4 | RAM write data |
| memWe | output | 1 | RAM write enable, sampled on the rising edge |
| acOut | output | 4 | Accumulator |
| dphOut | output | 4 | Pointer high nibble |
| dplOut | output | 4 | Pointer low nibble |
| zfOut | output | 1 | Zero flag |
| done | output | 1 | Last cycle of an operation |

## Verification
Directed sequences place the pointer at its wrap points: the low nibble at 15 before an increment and at 0 before a decrement. These show that a modulo-16 step does not carry into the high nibble and that the flag is taken from the post-step value. Zero and non-zero operands are set up for the load, the pointer transfer and the OR-exchange (including mask 000 on a zero high nibble). These separate "flag from result" from "flag left alone". Every spare register is swapped out and back. A second valid opcode is injected during an exchange to show that it is ignored. Seeded random opcodes drawn from all 256 codes then mix the defined operations with no-operations over a randomly filled RAM. Registers and the whole RAM image are compared against a bench model.

// File: rtl/nibble_pkg.sv
package nibble_pkg;
  localparam int NIB_W      = 4;
  localparam int ADDR_W     = 2 * NIB_W;
  localparam int OPC_W      = 8;
  localparam int NUM_AREG   = 4;
  localparam int AIDX_W     = $clog2(NUM_AREG);
  localparam int NUM_SHADOW = 2;

  typedef enum logic [4:0] {
    OP_NOP, OP_LDAC, OP_LDPTR, OP_LDHI, OP_STORE, OP_LOAD,
    OP_XMOR, OP_XINC, OP_XDEC, OP_INC, OP_DEC, OP_ACTOLO,
    OP_LOTOAC, OP_XACHI, OP_XAREG, OP_XHSPARE, OP_XLSPARE
  } opKind_e;

  typedef struct packed {
    logic             exec;
    logic             capture;
    logic             memWe;
    opKind_e          kind;
    logic [NIB_W-1:0] imm;
  } ctrlStrobe_t;

  function automatic opKind_e decodeOp(input logic [OPC_W-1:0] opc);
    opKind_e k;
    casez (opc)
      8'b1100_????: k = OP_LDAC;
      8'b1000_????: k = OP_LDPTR;
      8'b0100_????: k = OP_LDHI;
      8'b0000_0010: k = OP_STORE;
      8'b0010_0001: k = OP_LOAD;
      8'b1010_0???: k = OP_XMOR;
      8'b1111_1110: k = OP_XINC;
      8'b1111_1111: k = OP_XDEC;
      8'b1110_1110: k = OP_INC;
      8'b1110_1111: k = OP_DEC;
      8'b1111_0111: k = OP_ACTOLO;
      8'b1110_1001: k = OP_LOTOAC;
      8'b0010_0011: k = OP_XACHI;
      8'b1110_??00: k = OP_XAREG;
      8'b1111_1?00: k = OP_XHSPARE;
      8'b1111_0?00: k = OP_XLSPARE;
      default:      k = OP_NOP;
    endcase
    return k;
  endfunction

  function automatic logic isMemXch(input opKind_e k);
    return (k == OP_XMOR) || (k == OP_XINC) || (k == OP_XDEC);
  endfunction
endpackage

// File: rtl/nibble_ctrl.sv
module nibble_ctrl
  import nibble_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             opValid,
  input  logic [OPC_W-1:0] opcode,
  output ctrlStrobe_t      strobe,
  output logic             done
);
  opKind_e          decoded;
  opKind_e          heldKind;
  logic [NIB_W-1:0] heldImm;
  logic             phase2;

  assign decoded = decodeOp(opcode);

  always_comb begin
    strobe = '0;
    done   = 1'b0;
    if (phase2) begin
      strobe.exec  = 1'b1;
      strobe.memWe = 1'b1;
      strobe.kind  = heldKind;
      strobe.imm   = heldImm;
      done         = 1'b1;
    end else if (opValid) begin
      if (isMemXch(decoded)) begin
        strobe.capture = 1'b1;
      end else begin
        strobe.exec  = 1'b1;
        strobe.kind  = decoded;
        strobe.imm   = opcode[NIB_W-1:0];
        strobe.memWe = (decoded == OP_STORE);
        done         = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase2   <= 1'b0;
      heldKind <= OP_NOP;
      heldImm  <= '0;
    end else begin
      phase2 <= !phase2 && opValid && isMemXch(decoded);
      if (strobe.capture) begin
        heldKind <= decoded;
        heldImm  <= opcode[NIB_W-1:0];
      end
    end
  end
endmodule

// File: rtl/nibble_dpath.sv
module nibble_dpath
  import nibble_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [NIB_W-1:0]  memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [NIB_W-1:0]  memWdata,
  output logic              memWe,
  output logic [NIB_W-1:0]  ac,
  output logic [NIB_W-1:0]  dph,
  output logic [NIB_W-1:0]  dpl,
  output logic              zf
);
  logic [NIB_W-1:0] aReg [NUM_AREG];
  logic [NIB_W-1:0] hReg [NUM_SHADOW];
  logic [NIB_W-1:0] lReg [NUM_SHADOW];
  logic [NIB_W-1:0] fetched;
  logic [NIB_W-1:0] dplUp, dplDown, dphOr;
  logic [AIDX_W-1:0] aIdx;
  logic              sIdx;

  assign memAddr  = {dph, dpl};
  assign memWdata = ac;
  assign memWe    = strobe.memWe;
  assign dplUp    = dpl + NIB_W'(1);
  assign dplDown  = dpl - NIB_W'(1);
  assign dphOr    = dph | {1'b0, strobe.imm[NIB_W-2:0]};
  assign aIdx     = strobe.imm[NIB_W-1 -: AIDX_W];
  assign sIdx     = strobe.imm[2];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ac      <= '0;
      dph     <= '0;
      dpl     <= '0;
      zf      <= 1'b0;
      fetched <= '0;
      for (int i = 0; i < NUM_AREG; i++)   aReg[i] <= '0;
      for (int i = 0; i < NUM_SHADOW; i++) begin
        hReg[i] <= '0;
        lReg[i] <= '0;
      end
    end else begin
      if (strobe.capture) fetched <= memRdata;
      if (strobe.exec) begin
        case (strobe.kind)
          OP_LDAC:   ac <= strobe.imm;
          OP_LDPTR:  begin dph <= '0; dpl <= strobe.imm; end
          OP_LDHI:   dph <= strobe.imm;
          OP_LOAD:   begin ac <= memRdata; zf <= (memRdata == '0); end
          OP_XMOR:   begin ac <= fetched; dph <= dphOr; zf <= (dphOr == '0); end
          OP_XINC:   begin ac <= fetched; dpl <= dplUp; zf <= (dplUp == '0); end
          OP_XDEC:   begin ac <= fetched; dpl <= dplDown; zf <= (dplDown == '0); end
          OP_INC:    begin dpl <= dplUp; zf <= (dplUp == '0); end
          OP_DEC:    begin dpl <= dplDown; zf <= (dplDown == '0); end
          OP_ACTOLO: dpl <= ac;
          OP_LOTOAC: begin ac <= dpl; zf <= (dpl == '0); end
          OP_XACHI:  begin ac <= dph; dph <= ac; end
          OP_XAREG:  begin ac <= aReg[aIdx]; aReg[aIdx] <= ac; end
          OP_XHSPARE: begin dph <= hReg[sIdx]; hReg[sIdx] <= dph; end
          OP_XLSPARE: begin dpl <= lReg[sIdx]; lReg[sIdx] <= dpl; end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/nibble_acc_unit.sv
module nibble_acc_unit
  import nibble_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [OPC_W-1:0]  opcode,
  input  logic [NIB_W-1:0]  memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [NIB_W-1:0]  memWdata,
  output logic              memWe,
  output logic [NIB_W-1:0]  acOut,
  output logic [NIB_W-1:0]  dphOut,
  output logic [NIB_W-1:0]  dplOut,
  output logic              zfOut,
  output logic              done
);
  ctrlStrobe_t strobe;

  nibble_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opcode(opcode),
    .strobe(strobe), .done(done)
  );

  nibble_dpath u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .memRdata(memRdata),
    .memAddr(memAddr), .memWdata(memWdata), .memWe(memWe),
    .ac(acOut), .dph(dphOut), .dpl(dplOut), .zf(zfOut)
  );
endmodule

// File: rtl/nibble_acc_unit_chk.sv
module nibble_acc_unit_chk (
  input logic       clk,
  input logic       rstN,
  input logic       opValid,
  input logic [7:0] opcode,
  input logic [3:0] memRdata,
  input logic [7:0] memAddr,
  input logic [3:0] memWdata,
  input logic       memWe,
  input logic [3:0] acOut,
  input logic [3:0] dphOut,
  input logic [3:0] dplOut,
  input logic       zfOut,
  input logic       done
);
  logic inXch;
  logic memX;
  logic start;

  assign memX  = (opcode[7:3] == 5'b10100) || (opcode[7:1] == 7'b1111111);
  assign start = opValid && !inXch;

  always_ff @(posedge clk) begin
    if (!rstN) inXch <= 1'b0;
    else       inXch <= start && memX;
  end

  // R11
  xch_second_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    inXch |-> (done && memWe));
  // R11
  xch_first_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && memX) |-> (!done && !memWe));
  // R11
  single_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !memX) |-> done);
  // R2
  imm_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && opcode[7:4] == 4'hC) |=> (acOut == $past(opcode[3:0]) && zfOut == $past(zfOut)));
  // R3
  store_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && opcode == 8'h02) |-> (memWe && memWdata == acOut && memAddr == {dphOut, dplOut}));
  // R4
  load_zf_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && opcode == 8'h21) |=> (acOut == $past(memRdata) && zfOut == ($past(memRdata) == 4'h0)));
  // R7
  dpl_inc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && opcode == 8'hEE) |=> (dplOut == 4'($past(dplOut) + 4'd1) && $stable(dphOut)));
  // R12
  nop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && opcode == 8'h00) |=> ($stable(acOut) && $stable(dphOut) && $stable(dplOut) && $stable(zfOut)));
  // R12
  write_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> (inXch || (opValid && opcode == 8'h02)));
endmodule

bind nibble_acc_unit nibble_acc_unit_chk u_chk (
  .clk(clk), .rstN(rstN), .opValid(opValid), .opcode(opcode),
  .memRdata(memRdata), .memAddr(memAddr), .memWdata(memWdata), .memWe(memWe),
  .acOut(acOut), .dphOut(dphOut), .dplOut(dplOut), .zfOut(zfOut), .done(done)
);

// File: tb/nibble_acc_unit_bench.sv
module nibble_acc_unit_bench;
  logic       clk = 1'b0;
  logic       rstN;
  logic       opValid;
  logic [7:0] opcode;
  logic [3:0] memRdata;
  logic [7:0] memAddr;
  logic [3:0] memWdata;
  logic       memWe;
  logic [3:0] acOut, dphOut, dplOut;
  logic       zfOut;
  logic       done;

  always #10 clk = ~clk;

  nibble_acc_unit u_nibble_acc_unit (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opcode(opcode),
    .memRdata(memRdata), .memAddr(memAddr), .memWdata(memWdata), .memWe(memWe),
    .acOut(acOut), .dphOut(dphOut), .dplOut(dplOut), .zfOut(zfOut), .done(done)
  );

  logic [3:0] ram [256];
  assign memRdata = ram[memAddr];
  always @(posedge clk) if (memWe) ram[memAddr] <= memWdata;

  logic [3:0] eAc, eDph, eDpl;
  logic       eZf;
  logic [3:0] eA [4];
  logic [3:0] eH [2];
  logic [3:0] eL [2];
  logic [3:0] eRam [256];
  int checks = 0;
  int fails  = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  function automatic bit twoCycle(input logic [7:0] op);
    return (op[7:3] == 5'b10100) || (op[7:1] == 7'b1111111);
  endfunction

  function automatic string reqOf(input logic [7:0] op);
    casez (op)
      8'b1100_????, 8'b1000_????, 8'b0100_????: return "R2";
      8'h02: return "R3";
      8'h21: return "R4";
      8'b1010_0???: return "R5";
      8'hFE, 8'hFF: return "R6";
      8'hEE, 8'hEF: return "R7";
      8'hF7, 8'hE9: return "R8";
      8'h23, 8'b1110_??00: return "R9";
      8'b1111_1?00, 8'b1111_0?00: return "R10";
      default: return "R12";
    endcase
  endfunction

  task automatic modelStep(input logic [7:0] op);
    logic [3:0] lo, t;
    lo = op[3:0];
    casez (op)
      8'b1100_????: eAc = lo;
      8'b1000_????: begin eDph = 4'h0; eDpl = lo; end
      8'b0100_????: eDph = lo;
      8'h02: eRam[{eDph, eDpl}] = eAc;
      8'h21: begin eAc = eRam[{eDph, eDpl}]; eZf = (eAc == 4'h0); end
      8'b1010_0???: begin
        t = eRam[{eDph, eDpl}]; eRam[{eDph, eDpl}] = eAc; eAc = t;
        eDph = eDph | {1'b0, lo[2:0]}; eZf = (eDph == 4'h0);
      end
      8'hFE: begin
        t = eRam[{eDph, eDpl}]; eRam[{eDph, eDpl}] = eAc; eAc = t;
        eDpl = 4'(eDpl + 4'd1); eZf = (eDpl == 4'h0);
      end
      8'hFF: begin
        t = eRam[{eDph, eDpl}]; eRam[{eDph, eDpl}] = eAc; eAc = t;
        eDpl = 4'(eDpl - 4'd1); eZf = (eDpl == 4'h0);
      end
      8'hEE: begin eDpl = 4'(eDpl + 4'd1); eZf = (eDpl == 4'h0); end
      8'hEF: begin eDpl = 4'(eDpl - 4'd1); eZf = (eDpl == 4'h0); end
      8'hF7: eDpl = eAc;
      8'hE9: begin eAc = eDpl; eZf = (eDpl == 4'h0); end
      8'h23: begin t = eAc; eAc = eDph; eDph = t; end
      8'b1110_??00: begin t = eAc; eAc = eA[lo[3:2]]; eA[lo[3:2]] = t; end
      8'b1111_1?00: begin t = eDph; eDph = eH[lo[2]]; eH[lo[2]] = t; end
      8'b1111_0?00: begin t = eDpl; eDpl = eL[lo[2]]; eL[lo[2]] = t; end
      default: ;
    endcase
  endtask

  task automatic checkState(input string tag);
    chk({tag, " accumulator"}, acOut, eAc);
    chk({tag, " pointer high"}, dphOut, eDph);
    chk({tag, " pointer low"}, dplOut, eDpl);
    chk({tag, " zero flag"}, zfOut, eZf);
  endtask

  // Runs one opcode; intrude drives a stray accumulator load during an exchange's second cycle.
  task automatic doOp(input logic [7:0] op, input bit intrude);
    bit    two;
    string tg;
    two = twoCycle(op);
    tg  = reqOf(op);
    @(negedge clk);
    opcode = op; opValid = 1'b1;
    #2;
    chk({"R11 done first cycle ", tg}, done, two ? 0 : 1);
    chk({tg, " write strobe first cycle"}, memWe, (op == 8'h02) ? 1 : 0);
    if (op == 8'h02) begin
      chk("R3 store address", memAddr, {eDph, eDpl});
      chk("R3 store data", memWdata, eAc);
    end
    @(negedge clk);
    if (two) begin
      if (intrude) begin opcode = 8'hCA; opValid = 1'b1; end
      else opValid = 1'b0;
      #2;
      chk({"R11 done second cycle ", tg}, done, 1);
      chk({tg, " write strobe second cycle"}, memWe, 1);
      chk({tg, " exchange address"}, memAddr, {eDph, eDpl});
      chk({tg, " exchange write data"}, memWdata, eAc);
      @(negedge clk);
    end
    opValid = 1'b0;
    modelStep(op);
    #2;
    checkState(intrude && two ? {"R11 intruder ignored ", tg} : tg);
  endtask

  task automatic compareRam(input string tag);
    int bad;
    bad = 0;
    for (int i = 0; i < 256; i++) if (ram[i] !== eRam[i]) bad++;
    chk({tag, " RAM mismatches"}, bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R11 watchdog expired actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    logic [31:0] seedSink;
    seedSink = $urandom(32'd918273);
    rstN = 1'b0; opValid = 1'b0; opcode = 8'h00;
    for (int i = 0; i < 256; i++) begin
      ram[i]  = 4'($urandom);
      eRam[i] = ram[i];
    end
    eAc = 0; eDph = 0; eDpl = 0; eZf = 0;
    for (int i = 0; i < 4; i++) eA[i] = 0;
    for (int i = 0; i < 2; i++) begin eH[i] = 0; eL[i] = 0; end
    repeat (3) @(negedge clk);
    #2;
    checkState("R1 reset");
    chk("R1 reset done", done, 0);
    chk("R1 reset write enable", memWe, 0);
    @(negedge clk);
    rstN = 1'b1;

    // R2 immediates
    doOp(8'hC7, 0); doOp(8'h85, 0); doOp(8'h43, 0);
    // R3 store, then R4 load of zero and non-zero
    doOp(8'hC0, 0); doOp(8'h02, 0); doOp(8'hC9, 0); doOp(8'h21, 0);
    doOp(8'hC6, 0); doOp(8'h02, 0); doOp(8'hC1, 0); doOp(8'h21, 0);
    // R5 plain exchange on zero high nibble, then OR masks
    doOp(8'h80, 0); doOp(8'hA0, 0); doOp(8'hA5, 0); doOp(8'hA2, 0);
    // R6 wrap at 15 and 0
    doOp(8'h8F, 0); doOp(8'h42, 0); doOp(8'hFE, 0); doOp(8'hFF, 0); doOp(8'hFF, 0);
    // R7 steps around the wrap
    doOp(8'h8E, 0); doOp(8'hEE, 0); doOp(8'hEE, 0); doOp(8'hEF, 0); doOp(8'hEF, 0);
    // R8 transfers
    doOp(8'hC0, 0); doOp(8'hF7, 0); doOp(8'hE9, 0); doOp(8'h8B, 0); doOp(8'hE9, 0);
    // R9 accumulator swaps
    doOp(8'hC3, 0); doOp(8'h23, 0);
    for (int t = 0; t < 4; t++) begin
      doOp(8'hC0 | 8'(t + 1), 0);
      doOp(8'hE0 | 8'(t << 2), 0);
    end
    for (int t = 0; t < 4; t++) doOp(8'hE0 | 8'(t << 2), 0);
    // R10 pointer spare swaps
    doOp(8'h4D, 0); doOp(8'hF8, 0); doOp(8'h4E, 0); doOp(8'hFC, 0); doOp(8'hF8, 0);
    doOp(8'h87, 0); doOp(8'hF0, 0); doOp(8'h89, 0); doOp(8'hF4, 0); doOp(8'hF0, 0);
    // R12 undefined codes
    doOp(8'h00, 0); doOp(8'h37, 0); doOp(8'hE1, 0); doOp(8'hFA, 0); doOp(8'hAF, 0);
    // R11 stray opcode during exchange
    doOp(8'hFE, 1); doOp(8'hA3, 1);
    compareRam("R5");

    for (int n = 0; n < 600; n++) doOp(8'($urandom), ($urandom % 4) == 0);
    compareRam("R6");

    summary();
    $finish;
  end
endmodule